// File: doc/BRIEF.md
# Single-Slope Fast PWM Timer

This block is an up-counting timer that drives pulse-width modulated waveforms on several compare channels. Each period runs from zero up to a selectable top value and then restarts at zero. The top can be one of three fixed resolutions (8, 9 or 10 bits). It can also come from a dedicated period register, or from the compare value of channel 0. Each channel compares the running count against its own compare value and shapes its pin in one of two polarities, or holds the pin low.

Compare values and the period register are double-buffered. Writes from the surrounding logic land in buffer registers, and the timer copies them into its working registers in the tick where the count wraps. Each period therefore runs on one consistent set of values. All activity advances only on cycles where the timer clock enable is high. Sticky event flags report overflow, per-channel matches and top-register matches until a clear strobe arrives.

Top module: `fpwm_timer`

## Requirements
- R1: The mode select chooses the top: code 5 gives 0x00FF, code 6 gives 0x01FF, code 7 gives 0x03FF, code 14 gives the working period register, code 15 gives the working compare value of channel 0. Under any other code the counter, the waveforms and all flags hold their values, apart from clear strobes.
- R2: On each enabled tick the count rises by one, and in the tick where it equals top it returns to zero, so a period lasts top+1 enabled ticks.
- R3: With output mode bits equal to 2 (non-inverting), a channel pin goes high after the tick where the count equals its working compare value and goes low after the tick where the count equals top; when both happen in one tick the pin goes low.
- R4: With output mode bits equal to 3 (inverting), the pin is the complement of the R3 waveform: low after a match, high after top.
- R5: With output mode bits equal to 0 or 1 the channel pin is held low.
- R6: The overflow flag is set in the tick where the count equals top.
- R7: A channel's match flag is set in the tick where the count equals its working compare value; under code 15 channel 0's match flag is therefore set in the same tick as the overflow flag.
- R8: The top-register flag is set, together with the overflow flag, in the tick where the count reaches top under code 14, and under no other code.
- R9: Every flag stays set until its clear strobe is high on a clock edge; a clear acts on any cycle, and a set event in the same cycle wins over the clear.
- R10: Writes go to buffer registers; the working compare values and the working period register take the buffer contents in the wrap tick, so a write during a period does not alter that period.
- R11: While the timer clock enable is low the count, the pins and the flags do not change, apart from clear strobes.
- R12: A register-defined top of 0x0003 gives a 4-tick period and a top of 0xFFFF gives a 65536-tick period.
- R13: After reset the count, all buffer and working registers, the waveforms and all flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tickEn | input | 1 | Timer clock enable; one enabled cycle is one tick |
| modeSel | input | 4 | Mode code selecting the top source |
| wrData | input | WIDTH | Write data for the buffer registers |
| cmpWrEn | input | NUM_CH | Per-channel compare buffer write strobes |
| topWrEn | input | 1 | Period buffer write strobe |
| outMode | input | 2*NUM_CH | Two output mode bits per channel, channel i at bits 2i+1:2i |
| cmpClr | input | NUM_CH | Per-channel match flag clear strobes |
| ovfClr | input | 1 | Overflow flag clear strobe |
| topClr | input | 1 | Top-register flag clear strobe |
| pwmOut | output | NUM_CH | Channel pins |
| cmpFlag | output | NUM_CH | Per-channel match flags |
| ovfFlag | output | 1 | Overflow flag |
| topFlag | output | 1 | Top-register match flag |

## Verification
The bound checker watches, on every cycle, that disconnected channels hold their pins low, that flags stay set until cleared, that nothing moves on cycles without a tick or under a non-PWM code, and that the top-register flag rises only under code 14 together with overflow. The exact pin edges within a period, the point where buffered values take effect, and the period lengths for each top source, including the 2-bit and 16-bit extremes, can only be shown by the bench's scenarios. The bench compares each output against a tick-by-tick model of the requirements.

// File: rtl/fpwm_pkg.sv
package fpwm_pkg;

  localparam logic [3:0] MODE_FIX8   = 4'd5;
  localparam logic [3:0] MODE_FIX9   = 4'd6;
  localparam logic [3:0] MODE_FIX10  = 4'd7;
  localparam logic [3:0] MODE_REGTOP = 4'd14;
  localparam logic [3:0] MODE_CMPTOP = 4'd15;

  localparam logic [1:0] OUT_NONINV = 2'd2;
  localparam logic [1:0] OUT_INV    = 2'd3;

  typedef enum logic [2:0] {
    SRC_HALT,
    SRC_FIX8,
    SRC_FIX9,
    SRC_FIX10,
    SRC_REGTOP,
    SRC_CMPTOP
  } topSrc_e;

  // strobes from control to datapath and output stage
  typedef struct packed {
    logic advance;    // counter moves this cycle
    logic wrap;       // count equals top on an advancing cycle
    logic regTopEvt;  // wrap while the period register defines top
  } ctrlStrb_t;

endpackage

// File: rtl/fpwm_ctrl.sv
module fpwm_ctrl
  import fpwm_pkg::*;
(
  input  logic      tickEn,
  input  logic [3:0] modeSel,
  input  logic      atTop,
  output topSrc_e   topSrc,
  output ctrlStrb_t strb
);

  always_comb begin
    case (modeSel)
      MODE_FIX8:   topSrc = SRC_FIX8;
      MODE_FIX9:   topSrc = SRC_FIX9;
      MODE_FIX10:  topSrc = SRC_FIX10;
      MODE_REGTOP: topSrc = SRC_REGTOP;
      MODE_CMPTOP: topSrc = SRC_CMPTOP;
      default:     topSrc = SRC_HALT;
    endcase
  end

  always_comb begin
    strb.advance   = tickEn && (topSrc != SRC_HALT);
    strb.wrap      = strb.advance && atTop;
    strb.regTopEvt = strb.wrap && (topSrc == SRC_REGTOP);
  end

endmodule

// File: rtl/fpwm_datapath.sv
module fpwm_datapath
  import fpwm_pkg::*;
#(
  parameter int WIDTH  = 16,
  parameter int NUM_CH = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  topSrc_e           topSrc,
  input  ctrlStrb_t         strb,
  input  logic [WIDTH-1:0]  wrData,
  input  logic [NUM_CH-1:0] cmpWrEn,
  input  logic              topWrEn,
  output logic              atTop,
  output logic [NUM_CH-1:0] matchVec
);

  localparam logic [WIDTH-1:0] TOP_FIX8  = WIDTH'((1 << 8) - 1);
  localparam logic [WIDTH-1:0] TOP_FIX9  = WIDTH'((1 << 9) - 1);
  localparam logic [WIDTH-1:0] TOP_FIX10 = WIDTH'((1 << 10) - 1);
  localparam logic [WIDTH-1:0] ONE       = WIDTH'(1);

  logic [WIDTH-1:0] cnt;
  logic [WIDTH-1:0] topBuf;
  logic [WIDTH-1:0] topAct;
  logic [WIDTH-1:0] cmpBuf [NUM_CH];
  logic [WIDTH-1:0] cmpAct [NUM_CH];
  logic [WIDTH-1:0] topVal;

  // period register: buffer written any time, working copy loads at wrap
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      topBuf <= '0;
      topAct <= '0;
    end else begin
      if (strb.wrap) topAct <= topBuf;
      if (topWrEn)   topBuf <= wrData;
    end
  end

  generate
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : gCmp
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          cmpBuf[ch] <= '0;
          cmpAct[ch] <= '0;
        end else begin
          if (strb.wrap)   cmpAct[ch] <= cmpBuf[ch];
          if (cmpWrEn[ch]) cmpBuf[ch] <= wrData;
        end
      end
      assign matchVec[ch] = (cnt == cmpAct[ch]);
    end
  endgenerate

  always_comb begin
    case (topSrc)
      SRC_FIX8:   topVal = TOP_FIX8;
      SRC_FIX9:   topVal = TOP_FIX9;
      SRC_FIX10:  topVal = TOP_FIX10;
      SRC_CMPTOP: topVal = cmpAct[0];
      default:    topVal = topAct;
    endcase
  end

  assign atTop = (cnt == topVal);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strb.advance) begin
      cnt <= strb.wrap ? '0 : cnt + ONE;
    end
  end

endmodule

// File: rtl/fpwm_outstage.sv
module fpwm_outstage
  import fpwm_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrb_t           strb,
  input  logic [NUM_CH-1:0]   matchVec,
  input  logic [2*NUM_CH-1:0] outMode,
  input  logic [NUM_CH-1:0]   cmpClr,
  input  logic                ovfClr,
  input  logic                topClr,
  output logic [NUM_CH-1:0]   pwmOut,
  output logic [NUM_CH-1:0]   cmpFlag,
  output logic                ovfFlag,
  output logic                topFlag
);

  logic [NUM_CH-1:0] wave;

  generate
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : gChan
      logic [1:0] chMode;
      assign chMode = outMode[2*ch +: 2];

      // top has priority over a match in the same tick
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          wave[ch] <= 1'b0;
        end else if (strb.advance) begin
          if (strb.wrap)        wave[ch] <= 1'b0;
          else if (matchVec[ch]) wave[ch] <= 1'b1;
        end
      end

      // set wins over clear
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          cmpFlag[ch] <= 1'b0;
        end else if (strb.advance && matchVec[ch]) begin
          cmpFlag[ch] <= 1'b1;
        end else if (cmpClr[ch]) begin
          cmpFlag[ch] <= 1'b0;
        end
      end

      always_comb begin
        case (chMode)
          OUT_NONINV: pwmOut[ch] = wave[ch];
          OUT_INV:    pwmOut[ch] = ~wave[ch];
          default:    pwmOut[ch] = 1'b0;
        endcase
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovfFlag <= 1'b0;
      topFlag <= 1'b0;
    end else begin
      if (strb.wrap)      ovfFlag <= 1'b1;
      else if (ovfClr)    ovfFlag <= 1'b0;
      if (strb.regTopEvt) topFlag <= 1'b1;
      else if (topClr)    topFlag <= 1'b0;
    end
  end

endmodule

// File: rtl/fpwm_timer.sv
module fpwm_timer
  import fpwm_pkg::*;
#(
  parameter int WIDTH  = 16,
  parameter int NUM_CH = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                tickEn,
  input  logic [3:0]          modeSel,
  input  logic [WIDTH-1:0]    wrData,
  input  logic [NUM_CH-1:0]   cmpWrEn,
  input  logic                topWrEn,
  input  logic [2*NUM_CH-1:0] outMode,
  input  logic [NUM_CH-1:0]   cmpClr,
  input  logic                ovfClr,
  input  logic                topClr,
  output logic [NUM_CH-1:0]   pwmOut,
  output logic [NUM_CH-1:0]   cmpFlag,
  output logic                ovfFlag,
  output logic                topFlag
);

  topSrc_e           topSrc;
  ctrlStrb_t         strb;
  logic              atTop;
  logic [NUM_CH-1:0] matchVec;

  fpwm_ctrl uCtrl (
    .tickEn  (tickEn),
    .modeSel (modeSel),
    .atTop   (atTop),
    .topSrc  (topSrc),
    .strb    (strb)
  );

  fpwm_datapath #(.WIDTH(WIDTH), .NUM_CH(NUM_CH)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .topSrc   (topSrc),
    .strb     (strb),
    .wrData   (wrData),
    .cmpWrEn  (cmpWrEn),
    .topWrEn  (topWrEn),
    .atTop    (atTop),
    .matchVec (matchVec)
  );

  fpwm_outstage #(.NUM_CH(NUM_CH)) uOut (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .matchVec (matchVec),
    .outMode  (outMode),
    .cmpClr   (cmpClr),
    .ovfClr   (ovfClr),
    .topClr   (topClr),
    .pwmOut   (pwmOut),
    .cmpFlag  (cmpFlag),
    .ovfFlag  (ovfFlag),
    .topFlag  (topFlag)
  );

endmodule

// File: rtl/fpwm_timer_chk.sv
module fpwm_timer_chk #(
  parameter int NUM_CH = 3
) (
  input logic                clk,
  input logic                rstN,
  input logic                tickEn,
  input logic [3:0]          modeSel,
  input logic [2*NUM_CH-1:0] outMode,
  input logic [NUM_CH-1:0]   cmpClr,
  input logic                ovfClr,
  input logic                topClr,
  input logic [NUM_CH-1:0]   pwmOut,
  input logic [NUM_CH-1:0]   cmpFlag,
  input logic                ovfFlag,
  input logic                topFlag
);

  function automatic logic isPwmCode(input logic [3:0] code);
    return (code == 4'd5) || (code == 4'd6) || (code == 4'd7) ||
           (code == 4'd14) || (code == 4'd15);
  endfunction

  generate
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : gChk
      assert_pin_off_R5: assert property (@(posedge clk) disable iff (!rstN)
        (outMode[2*ch+1] == 1'b0) |-> !pwmOut[ch]);

      assert_cmp_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
        ($past(cmpFlag[ch]) && !$past(cmpClr[ch])) |-> cmpFlag[ch]);

      assert_pin_idle_R11: assert property (@(posedge clk) disable iff (!rstN)
        (!$past(tickEn) && $stable(outMode)) |-> $stable(pwmOut[ch]));
    end
  endgenerate

  assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    ($past(ovfFlag) && !$past(ovfClr)) |-> ovfFlag);

  assert_top_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    ($past(topFlag) && !$past(topClr)) |-> topFlag);

  assert_ovf_idle_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(tickEn) && !$past(ovfClr)) |-> $stable(ovfFlag));

  assert_halt_code_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!isPwmCode($past(modeSel)) && !$past(ovfClr) && !$past(topClr))
      |-> ($stable(ovfFlag) && $stable(topFlag)));

  assert_topflag_src_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(topFlag) |-> (($past(modeSel) == 4'd14) && ovfFlag));

endmodule

bind fpwm_timer fpwm_timer_chk #(.NUM_CH(NUM_CH)) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .tickEn  (tickEn),
  .modeSel (modeSel),
  .outMode (outMode),
  .cmpClr  (cmpClr),
  .ovfClr  (ovfClr),
  .topClr  (topClr),
  .pwmOut  (pwmOut),
  .cmpFlag (cmpFlag),
  .ovfFlag (ovfFlag),
  .topFlag (topFlag)
);

// File: tb/tb_fpwm_timer.sv
module tb_fpwm_timer;

  localparam int CLK_PERIOD = 10;
  localparam int NCH = 3;
  localparam int WATCHDOG_CYCLES = 190000;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          tickEn = 1'b0;
  logic [3:0]    modeSel = '0;
  logic [15:0]   wrData = '0;
  logic [NCH-1:0] cmpWrEn = '0;
  logic          topWrEn = 1'b0;
  logic [2*NCH-1:0] outMode = '0;
  logic [NCH-1:0] cmpClr = '0;
  logic          ovfClr = 1'b0;
  logic          topClr = 1'b0;
  logic [NCH-1:0] pwmOut;
  logic [NCH-1:0] cmpFlag;
  logic          ovfFlag;
  logic          topFlag;

  fpwm_timer #(.WIDTH(16), .NUM_CH(NCH)) dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .modeSel(modeSel),
    .wrData(wrData), .cmpWrEn(cmpWrEn), .topWrEn(topWrEn), .outMode(outMode),
    .cmpClr(cmpClr), .ovfClr(ovfClr), .topClr(topClr),
    .pwmOut(pwmOut), .cmpFlag(cmpFlag), .ovfFlag(ovfFlag), .topFlag(topFlag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int    kind;   // 0 pin, 1 match flag, 2 overflow flag, 3 top flag
    int    idx;
    int    exp;
    string tag;
    string what;
  } item_t;

  item_t scoreQ[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // requirement model state
  int mode = 0;
  int cnt = 0;
  int actTop = 0, bufTop = 0;
  int actCmp [NCH] = '{0, 0, 0};
  int bufCmp [NCH] = '{0, 0, 0};
  int outMd  [NCH] = '{0, 0, 0};
  bit wave   [NCH] = '{0, 0, 0};
  bit eCmpF  [NCH] = '{0, 0, 0};
  bit eOvf = 0, eTopF = 0;
  int gapAt = -1;
  int pendAt = -1;
  logic [2:0] pendMask = '0;
  bit pendTop = 0;
  logic [15:0] pendData = '0;

  function automatic int topOf();
    case (mode)
      5:  return 16'h00FF;
      6:  return 16'h01FF;
      7:  return 16'h03FF;
      14: return actTop;
      15: return actCmp[0];
      default: return -1;
    endcase
  endfunction

  function automatic int expPin(input int i);
    case (outMd[i])
      2: return int'(wave[i]);
      3: return int'(!wave[i]);
      default: return 0;
    endcase
  endfunction

  function automatic string pinReq(input int i);
    case (outMd[i])
      2: return "R3 pin";
      3: return "R4 pin";
      default: return "R5 pin";
    endcase
  endfunction

  task automatic pushItem(input int kind, input int idx, input int exp,
                          input string tag, input string what);
    item_t it;
    it.kind = kind; it.idx = idx; it.exp = exp; it.tag = tag; it.what = what;
    scoreQ.push_back(it);
  endtask

  // driver: one clock of stimulus, model update, expected items queued
  task automatic step(input bit advEn, input bit clr, input logic [2:0] wrMask,
                      input bit wrT, input logic [15:0] d, input string tag);
    int topV;
    bit adv;
    bit atT;
    @(negedge clk);
    tickEn  = advEn;
    modeSel = 4'(mode);
    ovfClr  = clr;
    topClr  = clr;
    cmpClr  = {NCH{clr}};
    cmpWrEn = wrMask;
    topWrEn = wrT;
    wrData  = d;
    for (int i = 0; i < NCH; i++) outMode[2*i +: 2] = 2'(outMd[i]);
    topV = topOf();
    adv  = advEn && (topV >= 0);
    if (clr) begin
      eOvf = 0; eTopF = 0;
      for (int i = 0; i < NCH; i++) eCmpF[i] = 0;
    end
    if (adv) begin
      atT = (cnt == topV);
      for (int i = 0; i < NCH; i++) begin
        if (atT) wave[i] = 0;
        else if (cnt == actCmp[i]) wave[i] = 1;
        if (cnt == actCmp[i]) eCmpF[i] = 1;
      end
      if (atT) begin
        eOvf = 1;
        if (mode == 14) eTopF = 1;
        actTop = bufTop;
        for (int i = 0; i < NCH; i++) actCmp[i] = bufCmp[i];
        cnt = 0;
      end else begin
        cnt++;
      end
    end
    for (int i = 0; i < NCH; i++) if (wrMask[i]) bufCmp[i] = int'(d);
    if (wrT) bufTop = int'(d);
    for (int i = 0; i < NCH; i++) begin
      pushItem(0, i, expPin(i), tag, pinReq(i));
      pushItem(1, i, int'(eCmpF[i]), tag, "R7 match flag");
    end
    pushItem(2, 0, int'(eOvf), tag, "R6 overflow flag");
    pushItem(3, 0, int'(eTopF), tag, "R8 top flag");
  endtask

  // one full period starting at count zero; flags cleared on its first tick
  task automatic runPeriod(input string tag);
    bit first = 1;
    int guard = 0;
    logic [2:0] wm;
    bit wt;
    logic [15:0] dd;
    do begin
      if (gapAt >= 0 && gapAt == cnt) begin
        repeat (3) step(0, 0, 3'b000, 0, 16'h0, {tag, " R11 idle"});
        gapAt = -1;
      end
      wm = '0; wt = 0; dd = '0;
      if (pendAt >= 0 && pendAt == cnt) begin
        wm = pendMask; wt = pendTop; dd = pendData;
        pendAt = -1;
      end
      step(1, first, wm, wt, dd, tag);
      first = 0;
      guard++;
    end while (cnt != 0 && guard < 70000);
  endtask

  // monitor: compares queued expectations after each edge
  initial begin
    item_t it;
    int act;
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      while (scoreQ.size() > 0) begin
        it = scoreQ.pop_front();
        case (it.kind)
          0: act = int'(pwmOut[it.idx]);
          1: act = int'(cmpFlag[it.idx]);
          2: act = int'(ovfFlag);
          default: act = int'(topFlag);
        endcase
        checks++;
        if (act != it.exp) begin
          errors++;
          $display("FAIL %s [%s ch%0d] at %0t: got %0d expected %0d",
                   it.tag, it.what, it.idx, $time, act, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired: got running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R13: reset state, pins low with output modes 0
    step(0, 0, 3'b000, 0, 16'h0, "R13 reset");
    outMd = '{2, 3, 2};
    // R1: a non-PWM code holds everything even with ticks enabled
    mode = 0;
    step(1, 0, 3'b000, 0, 16'h0, "R1 halt code");
    step(1, 0, 3'b000, 0, 16'h0, "R1 halt code");

    // buffer writes while halted
    step(0, 0, 3'b000, 1, 16'd5, "R10 write period");
    step(0, 0, 3'b001, 0, 16'd2, "R10 write cmp0");
    step(0, 0, 3'b010, 0, 16'd0, "R10 write cmp1");
    step(0, 0, 3'b100, 0, 16'd5, "R10 write cmp2");

    // period register top; working top still zero, so a 1-tick period loads buffers
    mode = 14;
    runPeriod("R10 load at wrap");
    runPeriod("R2 top 5");          // cmp1 = 0 also shows set winning over clear (R9)
    gapAt = 3;
    runPeriod("R11 gap in period");
    pendAt = 2; pendMask = 3'b010; pendTop = 1; pendData = 16'd3;
    runPeriod("R10 mid-period write");
    runPeriod("R12 top 3 two-bit");

    // R5: disconnected channel modes
    outMd = '{1, 0, 2};
    runPeriod("R5 disconnected");
    outMd = '{2, 3, 2};

    // R7: channel 0 compare defines top
    mode = 15;
    pendAt = 1; pendMask = 3'b001; pendTop = 0; pendData = 16'd6;
    runPeriod("R7 cmp0 top 2");
    runPeriod("R7 cmp0 top 6");

    // R1: fixed resolutions
    mode = 5;
    runPeriod("R1 fixed 8-bit");
    mode = 6;
    runPeriod("R1 fixed 9-bit");
    mode = 7;
    runPeriod("R1 fixed 10-bit");

    // R9: flags hold without clear, then clear while no event
    mode = 0;
    step(1, 0, 3'b000, 0, 16'h0, "R9 sticky under halt");
    step(1, 0, 3'b000, 0, 16'h0, "R9 sticky under halt");
    step(1, 1, 3'b000, 0, 16'h0, "R9 clear");
    step(0, 0, 3'b000, 1, 16'hFFFF, "R10 write full period");

    // R12: full 16-bit period
    mode = 14;
    runPeriod("R12 load full top");
    runPeriod("R12 top FFFF");

    @(negedge clk);
    tickEn = 1'b0;
    cmpWrEn = '0; topWrEn = 1'b0;
    ovfClr = 1'b0; topClr = 1'b0; cmpClr = '0;
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/2);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule